// File: doc/BRIEF.md
# Card Status Word Register

This block keeps the 32-bit status word that a memory card returns in its short responses. The command and data engines report events by pulsing one strobe per bit position. Each stored bit then stays set until its own clearing rule removes it. A few fields are not stored. The card-locked flag, the ECC-disabled flag, the ready-for-data flag and the 4-bit current-state field are copied from live card state inputs at the moment a response is built.

When the response engine is about to serialize a response, it pulses `rd_stb`. On that clock edge the block captures the word into `snap_word`. Bits that clear on read are wiped on the same edge, after the capture. Two error bits relate only to the previous command: command CRC error and illegal command. They survive reads. They are cleared by the first valid command that follows a response in which they were reported. That gives a lag of one command.

The snapshot is a one-way output. `snap_vld` rises with the first capture and stays high from then on. There is no ready input and no back-pressure. The consumer must take `snap_word` before it issues the next `rd_stb`, because each new capture overwrites the previous one.

Top module: `csr_status_reg`

## Requirements
- R1: After reset, `snap_word` is 0, `snap_vld` is 0, and every stored bit is clear.
- R2: A pulse on `rd_stb` at a clock edge loads `snap_word` on that edge. `snap_vld` is high from that edge onward.
- R3: A pulse on `evt_set[i]` sets stored bit i when i is a latched position. The bit stays set until its clearing rule fires.
- R4: The clear-on-read positions are 31, 30, 29, 28, 27, 26, 24, 21, 20, 19, 18, 17, 16, 15, 13 and 5. The snapshot shows their stored value, and the capture edge then clears them.
- R5: If a set strobe arrives on the same edge as a clear event for that bit (a read or a clearing command), the bit is set after the edge. A snapshot taken on that edge shows the value from before the edge.
- R6: Positions 23 and 22 are not cleared by reads. Once a snapshot has shown such a bit as 1, the next `cmd_ok` pulse clears it. A `cmd_ok` pulse before any such snapshot leaves it set.
- R7: Live fields are sampled at the capture edge: bit 25 from `st_locked`, bit 14 from `st_ecc_off`, bit 8 from `st_ready`, and bits 12 to 9 from `st_state`, with bit 12 as the MSB.
- R8: Bits 7, 6 and 4 to 0 of `snap_word` are always 0. Strobes on `evt_set` at positions that are not latched (25, 14, 12 to 6, 4 to 0) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_set | input | 32 | One set strobe per status bit position |
| rd_stb | input | 1 | Capture the snapshot and apply clear-on-read |
| cmd_ok | input | 1 | A valid command has been received |
| st_locked | input | 1 | Live card-locked flag |
| st_ecc_off | input | 1 | Live ECC-disabled flag |
| st_ready | input | 1 | Live ready-for-data flag |
| st_state | input | 4 | Live current card state |
| snap_word | output | 32 | Captured status word for the response |
| snap_vld | output | 1 | A snapshot has been captured since reset |

## Verification
The assertions take for granted that all strobes are single-cycle synchronous pulses. They also assume the live state inputs are stable across each capture edge. `rd_stb` and `cmd_ok` may coincide with each other and with any mix of `evt_set` bits. The stimulus drives every input only on falling edges. It sweeps each of the 32 strobe positions one at a time, then all 128 combinations of the live fields. It finishes with a long pseudo-random mix in which set strobes, reads and valid commands collide freely.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int WORD_W    = 32;
  localparam int STATE_W   = 4;
  localparam int STATE_LSB = 9;
  localparam int LOCK_POS  = 25;
  localparam int ECC_POS   = 14;
  localparam int RDY_POS   = 8;

  // bits cleared when reported in a response
  localparam logic [WORD_W-1:0] MASK_RD_CLR  = 32'hFD3F_A020;
  // bits cleared by the valid command following their report
  localparam logic [WORD_W-1:0] MASK_CMD_CLR = 32'h00C0_0000;
  localparam logic [WORD_W-1:0] MASK_STICKY  = MASK_RD_CLR | MASK_CMD_CLR;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_RD_CLR = 2'd1,
    CLS_CMD    = 2'd2
  } clr_class_e;

  function automatic clr_class_e class_of(input int pos);
    if (MASK_RD_CLR[pos])       return CLS_RD_CLR;
    else if (MASK_CMD_CLR[pos]) return CLS_CMD;
    else                        return CLS_NONE;
  endfunction
endpackage

// File: rtl/csr_cell_rdclr.sv
module csr_cell_rdclr (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (rd_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/csr_cell_cmdclr.sv
module csr_cell_cmdclr (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  input  logic cmd_i,
  output logic q_o
);
  logic reported;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o      <= 1'b0;
      reported <= 1'b0;
    end else if (set_i) begin
      q_o      <= 1'b1;
      reported <= 1'b0;
    end else if (cmd_i && reported) begin
      q_o      <= 1'b0;
      reported <= 1'b0;
    end else if (rd_i && q_o) begin
      reported <= 1'b1;
    end
  end
endmodule

// File: rtl/csr_live_pack.sv
module csr_live_pack
  import csr_pkg::*;
(
  input  logic               locked_i,
  input  logic               ecc_off_i,
  input  logic               ready_i,
  input  logic [STATE_W-1:0] state_i,
  output logic [WORD_W-1:0]  live_o
);
  always_comb begin
    live_o = '0;
    live_o[LOCK_POS] = locked_i;
    live_o[ECC_POS]  = ecc_off_i;
    live_o[RDY_POS]  = ready_i;
    live_o[STATE_LSB +: STATE_W] = state_i;
  end
endmodule

// File: rtl/csr_status_reg.sv
module csr_status_reg
  import csr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WORD_W-1:0]   evt_set,
  input  logic                rd_stb,
  input  logic                cmd_ok,
  input  logic                st_locked,
  input  logic                st_ecc_off,
  input  logic                st_ready,
  input  logic [STATE_W-1:0]  st_state,
  output logic [WORD_W-1:0]   snap_word,
  output logic                snap_vld
);
  logic [WORD_W-1:0] held;
  logic [WORD_W-1:0] live;
  logic              unused_evt;

  assign unused_evt = ^(evt_set & ~MASK_STICKY);

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    if (class_of(i) == CLS_RD_CLR) begin : g_rd
      csr_cell_rdclr u_cell (
        .clk(clk), .rst_n(rst_n), .set_i(evt_set[i]), .rd_i(rd_stb),
        .q_o(held[i])
      );
    end else if (class_of(i) == CLS_CMD) begin : g_cmd
      csr_cell_cmdclr u_cell (
        .clk(clk), .rst_n(rst_n), .set_i(evt_set[i]), .rd_i(rd_stb),
        .cmd_i(cmd_ok), .q_o(held[i])
      );
    end else begin : g_none
      assign held[i] = 1'b0;
    end
  end

  csr_live_pack u_live (
    .locked_i(st_locked), .ecc_off_i(st_ecc_off), .ready_i(st_ready),
    .state_i(st_state), .live_o(live)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_word <= '0;
      snap_vld  <= 1'b0;
    end else if (rd_stb) begin
      snap_word <= held | live;
      snap_vld  <= 1'b1;
    end
  end
endmodule

// File: rtl/csr_status_chk.sv
module csr_status_chk
  import csr_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [WORD_W-1:0]  evt_set,
  input logic               rd_stb,
  input logic               cmd_ok,
  input logic               st_ready,
  input logic [STATE_W-1:0] st_state,
  input logic [WORD_W-1:0]  held,
  input logic [WORD_W-1:0]  snap_word,
  input logic               snap_vld
);
  assert_vld_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> snap_vld);

  assert_set_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_set & MASK_STICKY) != '0) |=>
      ((held & $past(evt_set & MASK_STICKY)) == $past(evt_set & MASK_STICKY)));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> ((held & MASK_RD_CLR) == $past(evt_set & MASK_RD_CLR)));

  assert_snap_shows_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> ((snap_word & MASK_STICKY) == $past(held & MASK_STICKY)));

  assert_cmd_bits_survive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ok |=> ((held & $past(held & MASK_CMD_CLR)) == $past(held & MASK_CMD_CLR)));

  assert_live_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (snap_word[STATE_LSB +: STATE_W] == $past(st_state)) &&
               (snap_word[RDY_POS] == $past(st_ready)));

  assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_word[7:6] == 2'b00) && (snap_word[4:0] == 5'b0));
endmodule

bind csr_status_reg csr_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .rd_stb(rd_stb),
  .cmd_ok(cmd_ok), .st_ready(st_ready), .st_state(st_state),
  .held(held), .snap_word(snap_word), .snap_vld(snap_vld)
);

// File: tb/sim_csr_status_reg.sv
module sim_csr_status_reg;
  localparam int PERIOD = 10;
  localparam logic [31:0] M_RD  = 32'hFD3F_A020; // 31..26 minus 25, 24, 21..16, 15, 13, 5
  localparam logic [31:0] M_CMD = 32'h00C0_0000; // 23, 22

  logic clk = 0, rst_n = 0;
  logic [31:0] evt_set = '0;
  logic rd_stb = 0, cmd_ok = 0, st_locked = 0, st_ecc_off = 0, st_ready = 0;
  logic [3:0] st_state = '0;
  logic [31:0] snap_word;
  logic snap_vld;

  int errs = 0, checks = 0;
  logic [31:0] m_held = '0;
  logic [31:0] m_rep  = '0;
  logic [31:0] rng = 32'h1234_5678;

  csr_status_reg u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] live_word(input logic lk, input logic ec,
                                            input logic rd, input logic [3:0] st);
    return ({31'b0, lk} << 25) | ({31'b0, ec} << 14) | ({31'b0, rd} << 8) |
           ({28'b0, st} << 9);
  endfunction

  task automatic step(input logic [31:0] s, input logic r, input logic c,
                      input logic [3:0] st, input logic lk, input logic ec, input logic rdy);
    logic [31:0] exp_snap;
    @(negedge clk);
    evt_set = s; rd_stb = r; cmd_ok = c;
    st_state = st; st_locked = lk; st_ecc_off = ec; st_ready = rdy;
    exp_snap = (m_held & (M_RD | M_CMD)) | live_word(lk, ec, rdy, st);
    @(posedge clk); #1;
    if (r) begin
      chk("R2 vld", {31'b0, snap_vld}, 32'd1);
      chk("R4 rdclr field", snap_word & M_RD, exp_snap & M_RD);
      chk("R6 cmdclr field", snap_word & M_CMD, exp_snap & M_CMD);
      chk("R7 live field", snap_word & 32'h0200_5F00, exp_snap & 32'h0200_5F00);
      chk("R8 unused zero", snap_word & 32'h0000_00DF, 32'h0);
    end
    // model of stored bits
    for (int i = 0; i < 32; i++) begin
      if (M_RD[i]) begin
        if (s[i]) m_held[i] = 1'b1;
        else if (r) m_held[i] = 1'b0;
      end else if (M_CMD[i]) begin
        if (s[i]) begin m_held[i] = 1'b1; m_rep[i] = 1'b0; end
        else if (c && m_rep[i]) begin m_held[i] = 1'b0; m_rep[i] = 1'b0; end
        else if (r && m_held[i]) m_rep[i] = 1'b1;
      end
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  initial begin
    #(PERIOD*150000);
    errs++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset word", snap_word, 32'h0);
    chk("R1 reset vld", {31'b0, snap_vld}, 32'h0);
    rst_n = 1;
    step('0, 1, 0, 4'h0, 0, 0, 0);
    chk("R1 nothing stored", snap_word, 32'h0);

    // R3/R8: each strobe position alone, read twice, command, read
    for (int i = 0; i < 32; i++) begin
      step(32'h1 << i, 0, 0, 4'h0, 0, 0, 0);
      step('0, 1, 0, 4'h0, 0, 0, 0);
      chk("R3 R8 single strobe", snap_word, (M_RD | M_CMD) & (32'h1 << i));
      step('0, 1, 0, 4'h0, 0, 0, 0);
      step('0, 0, 1, 4'h0, 0, 0, 0);
      step('0, 1, 0, 4'h0, 0, 0, 0);
      chk("R6 cleared after lag", snap_word, 32'h0);
    end

    // R6: command before any report does not clear
    step(32'h0080_0000, 0, 0, 4'h0, 0, 0, 0);
    step('0, 0, 1, 4'h0, 0, 0, 0);
    step('0, 1, 0, 4'h0, 0, 0, 0);
    chk("R6 early cmd keeps", snap_word, 32'h0080_0000);
    // R5: set with clearing command on same edge keeps bit
    step(32'h0080_0000, 0, 1, 4'h0, 0, 0, 0);
    step('0, 1, 0, 4'h0, 0, 0, 0);
    chk("R5 set beats cmd", snap_word, 32'h0080_0000);
    step('0, 0, 1, 4'h0, 0, 0, 0);
    // R5: set with read on same edge
    step(32'h8000_0000, 1, 0, 4'h0, 0, 0, 0);
    chk("R5 snap before set", snap_word, 32'h0);
    step('0, 1, 0, 4'h0, 0, 0, 0);
    chk("R5 set beats read", snap_word, 32'h8000_0000);

    // R7: every live combination
    for (int k = 0; k < 128; k++)
      step('0, 1, 0, k[3:0], k[4], k[5], k[6]);

    // mixed pseudo-random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a, b;
      rng = nxt(rng); a = rng;
      rng = nxt(rng); b = rng;
      step(a & b & nxt(b), b[0] & b[1], b[2] & b[3], a[3:0], a[4], a[5], a[6]);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule